// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is the device side of a serial port for a converter-style peripheral. A host drives a serial clock, an active-low select and a data input. The block answers on a data output with an output-enable, and it drives an active-low data-ready flag. All serial inputs are brought into the system clock domain with two-flop synchronisers. The block acts on the edges of the synchronised serial clock.

Every access is a transaction in two phases. First a command byte goes into the command register. It names one of four targets and gives the direction. Then a second frame reads or writes that target. The setup and auxiliary registers are each 8 bits wide and drive parallel outputs. The sample register is 16 bits wide and read-only. It is filled from a parallel sample strobe. The data-ready flag goes high for a blanking window before each load and goes low once the new word is in place. Reading the full sample register sets the flag high again. A long run of ones on the data input brings the port back to waiting for a command byte, which recovers a host that has lost its bit alignment.

Top module: `serial_regport`

## Requirements
- R1: After reset, drdyN is 1, doutOe is 0, setupReg and auxReg are 0, and the first 8 bits received are taken as a command byte.
- R2: Command byte layout: bit 7 is ignored on write, bits 6:5 select the target (0 command, 1 setup, 2 sample, 3 auxiliary), bit 4 is 1 for read and 0 for write, and bits 3:0 are reserved. Writing setup or auxiliary loads the 8 bits that follow, MSB first, onto setupReg or auxReg.
- R3: A read shifts out the selected register MSB first. The frame is 16 bits for the sample register and 8 bits for the others. DIN is sampled on the rising SCLK edge and DOUT changes on the falling edge.
- R4: RESYNC_LEN consecutive rising edges with DIN at 1 send the port back to waiting for a command byte, whatever phase it was in.
- R5: drdyN falls when a new word is loaded into the sample register. It returns to 1 when a full 16-bit read of that register completes.
- R6: A sample strobe that arrives while no sample read is in progress drives drdyN high at once. The load and the fall of drdyN follow only after BLANK_CYC clock cycles.
- R7: The sample register can be read again after drdyN has gone high and returns the same word, provided no new load has happened.
- R8: Reading the command register returns drdyN in bit 7, the last selection in bits 6:5, the last direction in bit 4, and zeros in bits 3:0.
- R9: With csN high, any partial frame is dropped, doutOe is 0 and the next frame is a command byte. doutOe is 1 only during a read frame with csN low.
- R10: A write frame aimed at the sample register is consumed and leaves the register unchanged.
- R11: A sample strobe that arrives during a sample-register read is held. The word being shifted out does not change, and the load and blanking take place after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idles high |
| csN | input | 1 | Active-low select; tie low for three-wire use |
| din | input | 1 | Serial data from host |
| newSample | input | 1 | One-cycle strobe marking a new converter word |
| sampleIn | input | 16 | Converter word captured on newSample |
| dout | output | 1 | Serial data to host |
| doutOe | output | 1 | Output enable for dout |
| drdyN | output | 1 | Active-low data-ready flag |
| setupReg | output | 8 | Contents of the setup register |
| auxReg | output | 8 | Contents of the auxiliary register |

## Verification
The bench builds the block with RESYNC_LEN set to 16 and BLANK_CYC set to 6. With the shorter run length, a resynchronisation can be forced partway through a read frame that was entered by accident, using a short bit stream. With a blanking window of six cycles, the bench can catch drdyN high between a strobe and its load at a fixed sampling point. The same window gives time to land a strobe in the middle of a 16-bit read and to watch the deferred load.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] SEL_COMM  = 2'd0;
  localparam logic [1:0] SEL_SETUP = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;
  localparam logic [1:0] SEL_AUX   = 2'd3;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_t;
  typedef enum logic [1:0] {UPD_IDLE, UPD_PEND, UPD_BLANK} upd_t;

  typedef struct packed {
    logic       shiftIn;
    logic       cmdLoad;
    logic       wrLoad;
    logic       outLoad;
    logic       outShift;
    logic       dataReadActive;
    logic       dataReadDone;
    logic [1:0] sel;
    logic       rd;
  } ctlStrobe_t;
endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RESYNC_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkRise,
  input  logic             sclkFall,
  input  logic             csHigh,
  input  logic             dinS,
  input  logic [REG_W-1:0] inByteNext,
  output ctlStrobe_t       stb,
  output logic             doutOe
);
  localparam int CNT_W  = $clog2(DATA_W) + 1;
  localparam int ONES_W = $clog2(RESYNC_LEN) + 1;
  localparam logic [CNT_W-1:0] LAST_REG  = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  lastBit;
  logic [1:0]        curSel;
  logic              curRd;
  logic              firstFall;
  logic [ONES_W-1:0] onesCnt;

  logic rxEdge, txEdge, resyncHit, frameEnd;
  logic [1:0] newSel;

  assign rxEdge    = sclkRise && !csHigh;
  assign txEdge    = sclkFall && !csHigh;
  assign resyncHit = rxEdge && dinS && (onesCnt == ONES_W'(RESYNC_LEN - 1));
  assign frameEnd  = rxEdge && !resyncHit && (bitCnt == lastBit);
  assign newSel    = inByteNext[6:5];

  function automatic logic [CNT_W-1:0] frameLast(input logic [1:0] s);
    return (s == SEL_DATA) ? LAST_DATA : LAST_REG;
  endfunction

  always_comb begin
    stb.shiftIn        = rxEdge;
    stb.cmdLoad        = frameEnd && (phase == PH_CMD);
    stb.wrLoad         = frameEnd && (phase == PH_WR);
    stb.outLoad        = txEdge && (phase == PH_RD) && firstFall;
    stb.outShift       = txEdge && (phase == PH_RD) && !firstFall;
    stb.dataReadActive = (phase == PH_RD) && (curSel == SEL_DATA);
    stb.dataReadDone   = frameEnd && (phase == PH_RD) && (curSel == SEL_DATA);
    stb.sel            = curSel;
    stb.rd             = curRd;
  end

  assign doutOe = (phase == PH_RD) && !csHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      lastBit   <= LAST_REG;
      curSel    <= SEL_COMM;
      curRd     <= 1'b0;
      firstFall <= 1'b0;
      onesCnt   <= '0;
    end else if (csHigh) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      lastBit   <= LAST_REG;
      firstFall <= 1'b0;
      onesCnt   <= '0;
    end else begin
      if (txEdge && phase == PH_RD) firstFall <= 1'b0;
      if (rxEdge) begin
        onesCnt <= dinS ? onesCnt + 1'b1 : '0;
        if (resyncHit) begin
          phase   <= PH_CMD;
          bitCnt  <= '0;
          lastBit <= LAST_REG;
          onesCnt <= '0;
        end else if (frameEnd) begin
          bitCnt <= '0;
          if (phase == PH_CMD) begin
            curSel <= newSel;
            curRd  <= inByteNext[4];
            if (inByteNext[4]) begin
              phase     <= PH_RD;
              lastBit   <= frameLast(newSel);
              firstFall <= 1'b1;
            end else if (newSel == SEL_COMM) begin
              phase   <= PH_CMD;
              lastBit <= LAST_REG;
            end else begin
              phase   <= PH_WR;
              lastBit <= frameLast(newSel);
            end
          end else begin
            phase   <= PH_CMD;
            lastBit <= LAST_REG;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (phase == PH_CMD && bitCnt == '0)); // R9
  AST_RESYNC_CMD: assert property (@(posedge clk) disable iff (!rstN)
    resyncHit |=> (phase == PH_CMD && bitCnt == '0)); // R4
  AST_DATA_FRAME_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RD && curSel == SEL_DATA) |-> (lastBit == LAST_DATA)); // R3
endmodule

// File: rtl/srp_dpath.sv
module srp_dpath
  import srp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLANK_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              dinS,
  input  logic              newSample,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [REG_W-1:0]  inByteNext,
  output logic              dout,
  output logic              drdyN,
  output logic [REG_W-1:0]  setupReg,
  output logic [REG_W-1:0]  auxReg
);
  localparam int PAD_W = DATA_W - REG_W;
  localparam int BCNT_W = $clog2(BLANK_CYC + 1);
  localparam logic [BCNT_W-1:0] BLANK_INIT = BCNT_W'(BLANK_CYC - 1);

  logic [REG_W-1:0]  shIn;
  logic [DATA_W-1:0] outSh;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] sampleBuf;
  logic [BCNT_W-1:0] blankCnt;
  upd_t              updState;
  logic [REG_W-1:0]  commByte;
  logic [DATA_W-1:0] loadWord;

  assign inByteNext = {shIn[REG_W-2:0], dinS};
  assign commByte   = {drdyN, stb.sel, stb.rd, 4'b0000};
  assign dout       = outSh[DATA_W-1];

  always_comb begin
    case (stb.sel)
      SEL_SETUP: loadWord = {setupReg, {PAD_W{1'b0}}};
      SEL_DATA:  loadWord = dataReg;
      SEL_AUX:   loadWord = {auxReg, {PAD_W{1'b0}}};
      default:   loadWord = {commByte, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn     <= '0;
      outSh    <= '0;
      setupReg <= '0;
      auxReg   <= '0;
    end else begin
      if (stb.shiftIn) shIn <= inByteNext;
      if (stb.wrLoad) begin
        if (stb.sel == SEL_SETUP) setupReg <= inByteNext;
        if (stb.sel == SEL_AUX)   auxReg   <= inByteNext;
      end
      if (stb.outLoad)       outSh <= loadWord;
      else if (stb.outShift) outSh <= {outSh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg   <= '0;
      sampleBuf <= '0;
      blankCnt  <= '0;
      updState  <= UPD_IDLE;
      drdyN     <= 1'b1;
    end else begin
      if (stb.dataReadDone) drdyN <= 1'b1;
      if (newSample) begin
        sampleBuf <= sampleIn;
        if (updState == UPD_IDLE) begin
          if (stb.dataReadActive) begin
            updState <= UPD_PEND;
          end else begin
            updState <= UPD_BLANK;
            blankCnt <= BLANK_INIT;
            drdyN    <= 1'b1;
          end
        end
      end else begin
        case (updState)
          UPD_PEND: if (!stb.dataReadActive) begin
            updState <= UPD_BLANK;
            blankCnt <= BLANK_INIT;
            drdyN    <= 1'b1;
          end
          UPD_BLANK: begin
            if (blankCnt != '0) begin
              blankCnt <= blankCnt - 1'b1;
            end else if (!stb.dataReadActive) begin
              dataReg  <= sampleBuf;
              drdyN    <= 1'b0;
              updState <= UPD_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DRDY_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drdyN) |-> ($past(updState) == UPD_BLANK)); // R6
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataReadActive |=> $stable(dataReg)); // R11
  AST_READ_RAISES_DRDY: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataReadDone |=> drdyN); // R5
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import srp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RESYNC_LEN = 32,
  parameter int BLANK_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  input  logic              newSample,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              dout,
  output logic              doutOe,
  output logic              drdyN,
  output logic [REG_W-1:0]  setupReg,
  output logic [REG_W-1:0]  auxReg
);
  logic [1:0] sclkSync, csSync, dinSync;
  logic       sclkPrev;
  logic       sclkRise, sclkFall;
  logic [REG_W-1:0] inByteNext;
  ctlStrobe_t stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= 2'b11;
      csSync   <= 2'b11;
      dinSync  <= 2'b00;
      sclkPrev <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[0], sclk};
      csSync   <= {csSync[0], csN};
      dinSync  <= {dinSync[0], din};
      sclkPrev <= sclkSync[1];
    end
  end

  assign sclkRise = sclkSync[1] && !sclkPrev;
  assign sclkFall = !sclkSync[1] && sclkPrev;

  srp_ctrl #(.DATA_W(DATA_W), .RESYNC_LEN(RESYNC_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csHigh(csSync[1]), .dinS(dinSync[1]), .inByteNext(inByteNext),
    .stb(stb), .doutOe(doutOe)
  );

  srp_dpath #(.DATA_W(DATA_W), .BLANK_CYC(BLANK_CYC)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dinS(dinSync[1]),
    .newSample(newSample), .sampleIn(sampleIn), .inByteNext(inByteNext),
    .dout(dout), .drdyN(drdyN), .setupReg(setupReg), .auxReg(auxReg)
  );

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    doutOe |-> !csSync[1]); // R9
endmodule

// File: tb/sim_serial_regport.sv
`timescale 1ns/1ps
module sim_serial_regport;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1, csN = 1'b1, din = 1'b0;
  logic newSample = 1'b0;
  logic [15:0] sampleIn = '0;
  logic dout, doutOe, drdyN;
  logic [7:0] setupReg, auxReg;

  int nChk = 0, nFail = 0;
  logic [15:0] expQ[$];
  string tagQ[$];
  logic [15:0] gotWord;
  event gotEv;

  always #4 clk = ~clk;

  serial_regport #(.DATA_W(16), .RESYNC_LEN(16), .BLANK_CYC(6)) u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .newSample(newSample), .sampleIn(sampleIn), .dout(dout),
    .doutOe(doutOe), .drdyN(drdyN), .setupReg(setupReg), .auxReg(auxReg)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(gotEv);
      if (expQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL scoreboard: got %h expected none", gotWord);
      end else begin
        chk(tagQ.pop_front(), gotWord, expQ.pop_front());
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic sampled);
    sclk = 1'b0;
    din  = b;
    waitClk(HP);
    sampled = dout;
    sclk = 1'b1;
    waitClk(HP);
  endtask

  task automatic sendByte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(v[i], s);
  endtask

  task automatic readWord(input int n, input string tag, input logic [15:0] exp,
                          output logic oeSeen);
    logic s;
    logic [15:0] w;
    w = '0;
    oeSeen = 1'b0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int i = 0; i < n; i++) begin
      sendBit(1'b0, s);
      if (i == 0) oeSeen = doutOe;
      w = {w[14:0], s};
    end
    gotWord = w;
    -> gotEv;
    waitClk(2);
  endtask

  task automatic strobe(input logic [15:0] v);
    sampleIn = v;
    newSample = 1'b1;
    waitClk(1);
    newSample = 1'b0;
  endtask

  initial begin : watchdog
    waitClk(100000);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : driver
    logic oe;
    logic s;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R1 reset state
    chk("R1 drdyN", {15'd0, drdyN}, 16'd1);
    chk("R1 doutOe", {15'd0, doutOe}, 16'd0);
    chk("R1 setupReg", {8'd0, setupReg}, 16'd0);
    chk("R1 auxReg", {8'd0, auxReg}, 16'd0);
    csN = 1'b0;
    waitClk(HP);
    // R1/R2 first byte is command; setup write
    sendByte(8'h20); sendByte(8'hA5);
    chk("R2 setup write", {8'd0, setupReg}, 16'h00A5);
    // R2 bit 7 ignored on command write
    sendByte(8'hE0); sendByte(8'h3C);
    chk("R2 aux write", {8'd0, auxReg}, 16'h003C);
    // R3 read setup, also R9 oe during read
    sendByte(8'h30); readWord(8, "R3 setup read", 16'h00A5, oe);
    chk("R9 doutOe in read", {15'd0, oe}, 16'd1);
    sendByte(8'h70); readWord(8, "R3 aux read", 16'h003C, oe);
    // R8 command read with drdyN high
    sendByte(8'h10); readWord(8, "R8 comm read drdy high", 16'h0090, oe);
    // R5/R6 sample load
    strobe(16'hBEEF);
    waitClk(2);
    chk("R6 drdyN high in blank", {15'd0, drdyN}, 16'd1);
    waitClk(20);
    chk("R5 drdyN low after load", {15'd0, drdyN}, 16'd0);
    // R6 second strobe while drdyN low
    strobe(16'hCAFE);
    waitClk(2);
    chk("R6 drdyN forced high", {15'd0, drdyN}, 16'd1);
    waitClk(20);
    chk("R6 drdyN low after blank", {15'd0, drdyN}, 16'd0);
    // R8 command read with drdyN low
    sendByte(8'h10); readWord(8, "R8 comm read drdy low", 16'h0010, oe);
    // R5 data read clears drdy
    sendByte(8'h50); readWord(16, "R5 data read", 16'hCAFE, oe);
    chk("R5 drdyN high after read", {15'd0, drdyN}, 16'd1);
    // R7 reread
    sendByte(8'h50); readWord(16, "R7 data reread", 16'hCAFE, oe);
    // R10 write to sample register ignored
    sendByte(8'h40); sendByte(8'h00); sendByte(8'h00);
    sendByte(8'h50); readWord(16, "R10 data unchanged", 16'hCAFE, oe);
    // R11 strobe during data read is held
    strobe(16'h5A5A);
    waitClk(30);
    sendByte(8'h50);
    expQ.push_back(16'h5A5A); tagQ.push_back("R11 word during strobe");
    begin
      logic [15:0] w;
      w = '0;
      for (int i = 0; i < 16; i++) begin
        if (i == 8) strobe(16'h1234);
        sendBit(1'b0, s);
        w = {w[14:0], s};
      end
      gotWord = w;
      -> gotEv;
      waitClk(2);
    end
    waitClk(30);
    chk("R11 drdyN low after held load", {15'd0, drdyN}, 16'd0);
    sendByte(8'h50); readWord(16, "R11 held word loaded", 16'h1234, oe);
    // R4 resync: 4 zeros + 16 ones after setup command
    sendByte(8'h20);
    for (int i = 0; i < 4; i++) sendBit(1'b0, s);
    for (int i = 0; i < 16; i++) sendBit(1'b1, s);
    sendByte(8'h60); sendByte(8'h11);
    chk("R4 aux after resync", {8'd0, auxReg}, 16'h0011);
    chk("R4 setup partial", {8'd0, setupReg}, 16'h000F);
    // R9 CS abort
    sendByte(8'h20);
    for (int i = 0; i < 3; i++) sendBit(1'b1, s);
    csN = 1'b1;
    waitClk(HP);
    chk("R9 doutOe with cs high", {15'd0, doutOe}, 16'd0);
    csN = 1'b0;
    waitClk(HP);
    sendByte(8'h60); sendByte(8'h22);
    chk("R9 aux after abort", {8'd0, auxReg}, 16'h0022);
    chk("R9 setup untouched", {8'd0, setupReg}, 16'h000F);
    waitClk(4);
    chk("R3 scoreboard drained", 16'(expQ.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule